// File: doc/BRIEF.md
# Dynamic Bus-Sizing Burst Sequencer

This block is the master side of an external bus. It accepts one internal transfer of 1, 2, 4 or 16 bytes, and it runs that transfer on an external port that is 8, 16 or 32 bits wide. It drives the address, a 2-bit size code, the direction, a one-clock transfer-start strobe, an address strobe, a transfer-in-progress flag and active-low byte enables. It then waits for the active-low acknowledge from the slave.

When the transfer is wider than the port, the block picks one of two sequences. It runs a single burst when bursting is enabled for the transfer's direction. Otherwise it splits the transfer into independent port-width cycles, with the address strobe released between them. The port width, the two burst enables and the termination source are supplied with each request and are captured when the request is accepted.

A single-clock `done` pulse closes every transfer. For reads, the assembled data is valid on `rd_data` while `done` is high. The next request may be accepted in the same clock as the final acknowledge, so that two bus cycles run with no idle clock between them.

Top module: `bsz_burst_seq`

## Requirements
- R1: The size code is 01 for a byte, 10 for a word, 00 for a longword and 11 for a 16-byte line. During a burst, every beat carries the code of the whole transfer.
- R2: A transfer wider than the port is a burst only when the enable for its direction is set (`cfg_rd_burst` for reads, `cfg_wr_burst` for writes). Either way it takes transfer-bytes / port-bytes beats. The port code is 01 for 8 bits, 10 for 16 bits, and 00 (or 11) for 32 bits.
- R3: With no wait states a burst takes 2-1-1-1 clocks: the start strobe is low for the first clock only, and each later beat takes one clock. A beat ends only on a clock where `bus_ta_n` is sampled low. While it is high, the address and strobes hold.
- R4: Within a burst the address advances by the port width on each beat and wraps inside the aligned 16-byte line.
- R5: In a split sequence each cycle has its own start strobe, and the address strobe is high for one clock between cycles. The size code is the transfer's code on the first cycle and the port code on every later cycle.
- R6: In a split sequence the address advances by the port width per cycle when `cfg_ext_term` is 0, and stays at the request address when it is 1.
- R7: `bus_tip_n` is low from the first address phase until the last beat ends, including the strobe gaps, and is high otherwise.
- R8: `done` is high for exactly the clock after the final acknowledged beat. Beat k carries transfer bytes k·L to k·L+L-1 on the low L byte lanes, where L is the smaller of transfer and port bytes. The byte enables are low for exactly those lanes. On a read, `rd_data` holds the bytes gathered in that order, and bytes above the transfer are zero.
- R9: A request presented while the final beat is acknowledged is accepted in that clock, and its address phase follows with no idle clock.
- R10: A transfer no wider than the port is one cycle of two clocks (without waits) carrying the transfer's own size code.
- R11: After reset all strobes are high, `done` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this clock when high with req_valid |
| req_addr | input | ADDR_W | Transfer start address |
| req_size | input | 2 | Transfer size code (R1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | LINE_BYTES*8 | Write data, transfer byte 0 in bits 7:0 |
| cfg_port | input | 2 | Port width code (R2) |
| cfg_rd_burst | input | 1 | Burst enable for reads |
| cfg_wr_burst | input | 1 | Burst enable for writes |
| cfg_ext_term | input | 1 | 1 = slave terminates externally (address holds in split) |
| bus_addr | output | ADDR_W | Bus address |
| bus_siz | output | 2 | Bus size code |
| bus_rd | output | 1 | 1 = read cycle |
| bus_ts_n | output | 1 | Transfer start, low for one clock |
| bus_as_n | output | 1 | Address strobe |
| bus_tip_n | output | 1 | Transfer in progress |
| bus_be_n | output | PORT_BYTES | Byte enables, active low |
| bus_wdata | output | PORT_BYTES*8 | Write data lanes |
| bus_rdata | input | PORT_BYTES*8 | Read data lanes |
| bus_ta_n | input | 1 | Transfer acknowledge, active low |
| done | output | 1 | Transfer complete pulse |
| rd_data | output | LINE_BYTES*8 | Assembled read data |

## Verification
The acknowledge of a transfer's final beat and the acceptance of the next request can fall in the same clock. In that clock `done` must be scheduled, `rd_data` must be captured, and the new request must be loaded, all without any of them disturbing the others. The bench provokes this by holding a second request valid while a line-read burst is still running. It then judges the result in three ways. The first transfer's assembled data must be intact. The second transfer's first beat must follow with its own start strobe and no strobe gap. The clock count with transfer-in-progress low must equal the sum of both transfers.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
    localparam logic [1:0] SZ_LONG = 2'b00;
    localparam logic [1:0] SZ_BYTE = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;
    localparam logic [1:0] SZ_LINE = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_GAP  = 2'd3
    } seq_state_e;

    // bytes carried by a transfer of the given size code
    function automatic logic [4:0] size_bytes(input logic [1:0] code);
        case (code)
            SZ_BYTE: size_bytes = 5'd1;
            SZ_WORD: size_bytes = 5'd2;
            SZ_LINE: size_bytes = 5'd16;
            default: size_bytes = 5'd4;
        endcase
    endfunction

    // bytes per beat of a port of the given width code
    function automatic logic [2:0] port_bytes(input logic [1:0] code);
        case (code)
            SZ_BYTE: port_bytes = 3'd1;
            SZ_WORD: port_bytes = 3'd2;
            default: port_bytes = 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/bsz_plan.sv
module bsz_plan
    import bsz_pkg::*;
#(
    parameter int CNT_W  = 5,
    parameter int LANE_W = 3
) (
    input  logic [1:0]        size_code,
    input  logic [1:0]        port_code,
    input  logic              is_write,
    input  logic              rd_en,
    input  logic              wr_en,
    output logic [LANE_W-1:0] lanes,
    output logic [CNT_W-1:0]  total,
    output logic              burst,
    output logic [1:0]        port_siz
);
    logic [4:0] xfer_b;
    logic [2:0] port_b;
    logic       wider;

    always_comb begin
        xfer_b   = size_bytes(size_code);
        port_b   = port_bytes(port_code);
        wider    = xfer_b > {2'b00, port_b};
        lanes    = wider ? LANE_W'(port_b) : LANE_W'(xfer_b);
        total    = CNT_W'(xfer_b);
        burst    = wider && (is_write ? wr_en : rd_en);
        port_siz = (port_code == SZ_BYTE || port_code == SZ_WORD) ? port_code : SZ_LONG;
    end
endmodule

// File: rtl/bsz_rd_asm.sv
module bsz_rd_asm #(
    parameter int LINE_BYTES = 16,
    parameter int PORT_BYTES = 4,
    parameter int CNT_W      = 5,
    parameter int LANE_W     = 3
) (
    input  logic [LINE_BYTES*8-1:0] acc_in,
    input  logic [CNT_W-1:0]        off,
    input  logic [LANE_W-1:0]       lanes,
    input  logic [PORT_BYTES*8-1:0] lane_data,
    output logic [LINE_BYTES*8-1:0] acc_out
);
    localparam int LSEL = (PORT_BYTES > 1) ? $clog2(PORT_BYTES) : 1;

    // each line byte takes the port lane at its distance from the beat offset
    for (genvar i = 0; i < LINE_BYTES; i++) begin : g_byte
        logic [CNT_W-1:0] rel;
        logic             hit;
        assign rel = CNT_W'(i) - off;
        assign hit = (CNT_W'(i) >= off) && (rel < CNT_W'(lanes));
        assign acc_out[i*8 +: 8] = hit ? lane_data[rel[LSEL-1:0]*8 +: 8] : acc_in[i*8 +: 8];
    end
endmodule

// File: rtl/bsz_wr_lane.sv
module bsz_wr_lane #(
    parameter int PORT_BYTES = 4,
    parameter int LANE_W     = 3
) (
    input  logic                    active,
    input  logic [LANE_W-1:0]       lanes,
    input  logic [PORT_BYTES*8-1:0] beat_data,
    output logic [PORT_BYTES-1:0]   be_n,
    output logic [PORT_BYTES*8-1:0] lane_out
);
    for (genvar j = 0; j < PORT_BYTES; j++) begin : g_lane
        logic used;
        assign used               = active && (LANE_W'(j) < lanes);
        assign be_n[j]            = !used;
        assign lane_out[j*8 +: 8] = used ? beat_data[j*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/bsz_burst_seq.sv
module bsz_burst_seq
    import bsz_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int PORT_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [1:0]              req_size,
    input  logic                    req_write,
    input  logic [LINE_BYTES*8-1:0] req_wdata,
    input  logic [1:0]              cfg_port,
    input  logic                    cfg_rd_burst,
    input  logic                    cfg_wr_burst,
    input  logic                    cfg_ext_term,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [1:0]              bus_siz,
    output logic                    bus_rd,
    output logic                    bus_ts_n,
    output logic                    bus_as_n,
    output logic                    bus_tip_n,
    output logic [PORT_BYTES-1:0]   bus_be_n,
    output logic [PORT_BYTES*8-1:0] bus_wdata,
    input  logic [PORT_BYTES*8-1:0] bus_rdata,
    input  logic                    bus_ta_n,
    output logic                    done,
    output logic [LINE_BYTES*8-1:0] rd_data
);
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int PORT_W = PORT_BYTES * 8;
    localparam int CNT_W  = $clog2(LINE_BYTES) + 1;
    localparam int LOFF   = $clog2(LINE_BYTES);
    localparam int LANE_W = $clog2(PORT_BYTES) + 1;

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        siz;
        logic [1:0]        port_siz;
        logic              rd;
        logic              burst;
        logic              ext;
        logic [LANE_W-1:0] lanes;
        logic [CNT_W-1:0]  off;
        logic [CNT_W-1:0]  total;
        logic [LINE_W-1:0] wsh;
        logic [LINE_W-1:0] racc;
        logic [LINE_W-1:0] rout;
        logic              done;
    } seq_t;

    seq_t q, d;

    // request plan, taken at acceptance
    logic [LANE_W-1:0] pl_lanes;
    logic [CNT_W-1:0]  pl_total;
    logic              pl_burst;
    logic [1:0]        pl_port_siz;

    bsz_plan #(.CNT_W(CNT_W), .LANE_W(LANE_W)) u_plan (
        .size_code (req_size),
        .port_code (cfg_port),
        .is_write  (req_write),
        .rd_en     (cfg_rd_burst),
        .wr_en     (cfg_wr_burst),
        .lanes     (pl_lanes),
        .total     (pl_total),
        .burst     (pl_burst),
        .port_siz  (pl_port_siz)
    );

    logic [LINE_W-1:0] merged;

    bsz_rd_asm #(
        .LINE_BYTES(LINE_BYTES), .PORT_BYTES(PORT_BYTES),
        .CNT_W(CNT_W), .LANE_W(LANE_W)
    ) u_asm (
        .acc_in    (q.racc),
        .off       (q.off),
        .lanes     (q.lanes),
        .lane_data (bus_rdata),
        .acc_out   (merged)
    );

    logic active;
    assign active = (q.st == ST_ADDR) || (q.st == ST_DATA);

    bsz_wr_lane #(.PORT_BYTES(PORT_BYTES), .LANE_W(LANE_W)) u_lane (
        .active    (active),
        .lanes     (q.lanes),
        .beat_data (q.wsh[PORT_W-1:0]),
        .be_n      (bus_be_n),
        .lane_out  (bus_wdata)
    );

    logic              beat_end;
    logic              last_beat;
    logic [CNT_W-1:0]  off_nx;
    logic [ADDR_W-1:0] addr_adv;
    logic              take;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        beat_end  = (q.st == ST_DATA) && !bus_ta_n;
        off_nx    = q.off + CNT_W'(q.lanes);
        last_beat = off_nx >= q.total;
        addr_adv  = {q.addr[ADDR_W-1:LOFF], q.addr[LOFF-1:0] + LOFF'(q.lanes)};
        req_ready = (q.st == ST_IDLE) || (beat_end && last_beat);
        take      = req_valid && req_ready;

        case (q.st)
            ST_ADDR: d.st = ST_DATA;
            ST_DATA: begin
                if (beat_end) begin
                    d.off = off_nx;
                    d.wsh = q.wsh >> {q.lanes, 3'b000};
                    if (q.rd) d.racc = merged;
                    if (last_beat) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        if (q.rd) d.rout = merged;
                    end else if (q.burst) begin
                        d.addr = addr_adv;
                    end else begin
                        d.st  = ST_GAP;
                        d.siz = q.port_siz;
                        if (!q.ext) d.addr = addr_adv;
                    end
                end
            end
            ST_GAP:  d.st = ST_ADDR;
            default: d.st = ST_IDLE;
        endcase

        if (take) begin
            d.st       = ST_ADDR;
            d.addr     = req_addr;
            d.siz      = req_size;
            d.port_siz = pl_port_siz;
            d.rd       = !req_write;
            d.burst    = pl_burst;
            d.ext      = cfg_ext_term;
            d.lanes    = pl_lanes;
            d.total    = pl_total;
            d.off      = '0;
            d.wsh      = req_wdata;
            d.racc     = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
            q.rd       <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign bus_addr  = q.addr;
    assign bus_siz   = q.siz;
    assign bus_rd    = q.rd;
    assign bus_ts_n  = (q.st != ST_ADDR);
    assign bus_as_n  = !active;
    assign bus_tip_n = (q.st == ST_IDLE);
    assign done      = q.done;
    assign rd_data   = q.rout;
endmodule

// File: rtl/bsz_seq_chk.sv
module bsz_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_ts_n,
    input logic              bus_as_n,
    input logic              bus_tip_n,
    input logic              bus_ta_n,
    input logic [1:0]        bus_siz,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              done
);
    // start strobe lasts a single clock
    assert_ts_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ts_n |=> bus_ts_n);

    // start strobe only inside an address strobe
    assert_ts_in_as_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ts_n |-> !bus_as_n);

    // a wait state holds address and strobe
    assert_wait_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n && bus_ts_n && bus_ta_n) |=> (!bus_as_n && $stable(bus_addr)));

    // size code never changes between beats sharing one address strobe
    assert_siz_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n && bus_ts_n && $past(!bus_as_n)) |-> $stable(bus_siz));

    // a strobe gap inside a transfer leads to a new address phase
    assert_gap_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_as_n && !bus_tip_n) |=> !bus_ts_n);

    // address strobe never outside transfer-in-progress
    assert_tip_covers_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_as_n |-> !bus_tip_n);

    // completion follows an acknowledged data beat and lasts one clock
    assert_done_after_ta_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(!bus_ta_n && !bus_as_n && bus_ts_n));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind bsz_burst_seq bsz_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_ts_n  (bus_ts_n),
    .bus_as_n  (bus_as_n),
    .bus_tip_n (bus_tip_n),
    .bus_ta_n  (bus_ta_n),
    .bus_siz   (bus_siz),
    .bus_addr  (bus_addr),
    .done      (done)
);

// File: tb/sim_bsz_burst_seq.sv
module sim_bsz_burst_seq;
    timeunit 1ns;
    timeprecision 1ps;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic [1:0]   req_size = '0;
    logic         req_write = 1'b0;
    logic [127:0] req_wdata = '0;
    logic [1:0]   cfg_port = '0;
    logic         cfg_rd_burst = 1'b0;
    logic         cfg_wr_burst = 1'b0;
    logic         cfg_ext_term = 1'b0;
    logic [31:0]  bus_addr;
    logic [1:0]   bus_siz;
    logic         bus_rd;
    logic         bus_ts_n;
    logic         bus_as_n;
    logic         bus_tip_n;
    logic [3:0]   bus_be_n;
    logic [31:0]  bus_wdata;
    logic [31:0]  bus_rdata = '0;
    logic         bus_ta_n = 1'b1;
    logic         done;
    logic [127:0] rd_data;

    always #10 clk = ~clk;

    bsz_burst_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .req_wdata(req_wdata), .cfg_port(cfg_port), .cfg_rd_burst(cfg_rd_burst),
        .cfg_wr_burst(cfg_wr_burst), .cfg_ext_term(cfg_ext_term),
        .bus_addr(bus_addr), .bus_siz(bus_siz), .bus_rd(bus_rd),
        .bus_ts_n(bus_ts_n), .bus_as_n(bus_as_n), .bus_tip_n(bus_tip_n),
        .bus_be_n(bus_be_n), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ta_n(bus_ta_n), .done(done), .rd_data(rd_data)
    );

    typedef struct {
        logic [31:0] addr;
        logic [1:0]  siz;
        logic [3:0]  be_n;
        logic [31:0] wdata;
        logic        rd;
        logic        new_cyc;
        logic        gap;
    } beat_t;

    beat_t exp_q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    int    pred_id = 0;
    int    mon_id = 0;
    int    tip_total = 0;
    bit    ws_mode = 1'b0;

    task automatic chk(input string rq, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic int xbytes(input logic [1:0] c);
        return (c == 2'b01) ? 1 : (c == 2'b10) ? 2 : (c == 2'b11) ? 16 : 4;
    endfunction
    function automatic int pbytes(input logic [1:0] c);
        return (c == 2'b01) ? 1 : (c == 2'b10) ? 2 : 4;
    endfunction
    function automatic int waits(input int id);
        return ws_mode ? (id % 3) : 0;
    endfunction
    function automatic logic [31:0] rdf(input int id);
        return 32'h9E37_79B9 * (id + 1);
    endfunction

    // responder and scoreboard monitor: one process, sampled on falling edges
    always @(negedge clk) begin
        static bit fresh = 1'b1;
        static bit saw_ts = 1'b0;
        static bit saw_gap = 1'b0;
        static int wl = 0;
        beat_t b;
        if (!rst_n) begin
            bus_ta_n = 1'b1;
            fresh = 1'b1; saw_ts = 1'b0; saw_gap = 1'b0;
        end else begin
            if (!bus_tip_n) tip_total++;
            if (!bus_ts_n) saw_ts = 1'b1;
            if (bus_as_n && !bus_tip_n) saw_gap = 1'b1;
            bus_ta_n = 1'b1;
            if (!bus_as_n && bus_ts_n) begin
                if (fresh) begin wl = waits(mon_id); fresh = 1'b0; end
                if (wl == 0) begin
                    bus_ta_n = 1'b0;
                    bus_rdata = rdf(mon_id);
                    if (exp_q.size() == 0) begin
                        chk("R2 unexpected beat", 1, 0);
                    end else begin
                        b = exp_q.pop_front();
                        chk("R4 R6 beat address", bus_addr, b.addr);
                        chk("R1 R5 size code", bus_siz, b.siz);
                        chk("R8 byte enables", bus_be_n, b.be_n);
                        chk("R8 direction", bus_rd, b.rd);
                        if (!b.rd) chk("R8 write lanes", bus_wdata, b.wdata);
                        chk("R3 R5 start strobe per cycle", saw_ts, b.new_cyc);
                        chk("R5 strobe gap", saw_gap, b.gap);
                    end
                    mon_id++;
                    fresh = 1'b1; saw_ts = 1'b0; saw_gap = 1'b0;
                end else begin
                    wl--;
                end
            end
        end
    end

    // push the expected beats of one request; returns its clock cost and read image
    task automatic plan_xfer(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                             input logic [127:0] wd, output int clks, output logic [127:0] erd);
        int xb, pb, ln, n;
        bit bu;
        beat_t b;
        logic [31:0] word;
        xb = xbytes(sz); pb = pbytes(cfg_port);
        ln = (xb > pb) ? pb : xb;
        n  = xb / ln;
        bu = (xb > pb) && (wr ? cfg_wr_burst : cfg_rd_burst);
        clks = 0; erd = '0;
        for (int k = 0; k < n; k++) begin
            b.addr    = (bu || !cfg_ext_term) ? {a[31:4], 4'(a[3:0] + k * ln)} : a;
            b.siz     = (bu || k == 0) ? sz : ((cfg_port == 2'b11) ? 2'b00 : cfg_port);
            b.be_n    = ~4'((1 << ln) - 1);
            b.wdata   = 32'(wd >> (k * ln * 8)) & ((ln == 4) ? 32'hFFFF_FFFF : ((32'd1 << (ln * 8)) - 1));
            b.rd      = !wr;
            b.new_cyc = (k == 0) || !bu;
            b.gap     = (k > 0) && !bu;
            clks += 1 + waits(pred_id) + (b.new_cyc ? 1 : 0) + (b.gap ? 1 : 0);
            word = rdf(pred_id);
            for (int l = 0; l < ln; l++) erd[(k * ln + l) * 8 +: 8] = word[l * 8 +: 8];
            pred_id++;
            exp_q.push_back(b);
        end
    endtask

    task automatic wait_done();
        for (int g = 0; g < 3000; g++) begin
            @(negedge clk); #1;
            if (done) return;
        end
        chk("R8 done never seen", 0, 1);
    endtask

    task automatic run_xfer(input string tag, input logic [31:0] a, input logic [1:0] sz,
                            input logic wr, input logic [127:0] wd, input logic [1:0] port,
                            input logic br, input logic bw, input logic et, input bit wsm);
        int clks, t0;
        logic [127:0] erd;
        @(negedge clk);
        cfg_port = port; cfg_rd_burst = br; cfg_wr_burst = bw; cfg_ext_term = et;
        ws_mode = wsm;
        plan_xfer(a, sz, wr, wd, clks, erd);
        t0 = tip_total;
        req_addr = a; req_size = sz; req_write = wr; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        chk({tag, " R7 R3 clocks in progress"}, tip_total - t0, clks);
        chk({tag, " R2 beat count"}, exp_q.size(), 0);
        if (!wr) chk({tag, " R8 read data"}, rd_data, erd);
        @(negedge clk); #1;
        chk({tag, " R8 done single clock"}, done, 0);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int c1, c2, t0;
        logic [127:0] e1, e2;
        repeat (3) @(negedge clk);
        #1;
        // R11 reset state
        chk("R11 ts_n", bus_ts_n, 1); chk("R11 as_n", bus_as_n, 1);
        chk("R11 tip_n", bus_tip_n, 1); chk("R11 done", done, 0);
        chk("R11 req_ready", req_ready, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_xfer("R10 long rd p32", 32'h0000_1000, 2'b00, 1'b0, '0, 2'b00, 1, 1, 0, 0);
        run_xfer("R10 byte wr p8",  32'h0000_1003, 2'b01, 1'b1, 128'hA5, 2'b01, 1, 1, 0, 0);
        run_xfer("R10 word wr p32", 32'h0000_1006, 2'b10, 1'b1, 128'hBEEF, 2'b00, 0, 0, 0, 1);
        run_xfer("R1 word rd p8 burst", 32'h0000_2002, 2'b10, 1'b0, '0, 2'b01, 1, 0, 0, 0);
        run_xfer("R1 long wr p8 burst waits", 32'h0000_2004, 2'b00, 1'b1, 128'h1122_3344, 2'b01, 0, 1, 1, 1);
        run_xfer("R4 line rd p32 wrap", 32'h0000_3008, 2'b11, 1'b0, '0, 2'b00, 1, 0, 0, 0);
        run_xfer("R3 line wr p16 waits", 32'h0000_3010, 2'b11, 1'b1,
                 128'h0F0E_0D0C_0B0A_0908_0706_0504_0302_0100, 2'b10, 0, 1, 1, 1);
        run_xfer("R5 R6 line rd split int", 32'h0000_4000, 2'b11, 1'b0, '0, 2'b00, 0, 1, 0, 0);
        run_xfer("R6 line rd split ext", 32'h0000_4010, 2'b11, 1'b0, '0, 2'b00, 0, 1, 1, 1);
        run_xfer("R2 line wr p8 split", 32'h0000_5000, 2'b11, 1'b1,
                 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F, 2'b01, 1, 0, 0, 1);
        run_xfer("R5 long rd p16 split", 32'h0000_5104, 2'b00, 1'b0, '0, 2'b10, 0, 0, 0, 0);

        // R9 back-to-back: second request waits while the first burst runs
        @(negedge clk);
        cfg_port = 2'b00; cfg_rd_burst = 1'b1; cfg_wr_burst = 1'b1; cfg_ext_term = 1'b0;
        ws_mode = 1'b0;
        plan_xfer(32'h0000_6000, 2'b11, 1'b0, '0, c1, e1);
        plan_xfer(32'h0000_7000, 2'b00, 1'b1, 128'hCAFE_F00D, c2, e2);
        t0 = tip_total;
        req_addr = 32'h0000_6000; req_size = 2'b11; req_write = 1'b0; req_wdata = '0;
        req_valid = 1'b1;
        @(negedge clk);
        req_addr = 32'h0000_7000; req_size = 2'b00; req_write = 1'b1; req_wdata = 128'hCAFE_F00D;
        wait_done();
        req_valid = 1'b0;
        chk("R9 first read data", rd_data, e1);
        chk("R9 second already started", bus_tip_n, 0);
        wait_done();
        chk("R9 clocks in progress, no idle", tip_total - t0, c1 + c2);
        chk("R9 beat count", exp_q.size(), 0);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule